// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block derives the serial clock of an I2C master from the peripheral clock. A 32-bit timing word holds three fields: a base exponent E, a low-phase count L and a high-phase count H. A prescaler cuts the peripheral clock into base ticks, one every 2^E cycles. Two phase counters then hold the serial clock low for L+1 ticks and high for H+1 ticks. A byte-level master engine uses the one-cycle strobes at each phase start to drive or release the line.

A separate combinational helper turns a requested bus speed into a timing word. It first forms the ratio of the peripheral clock to the speed. It halves that ratio until it drops below 16, rounding up when any bit shifted out was set. It then splits the reduced ratio into the two phase counts. All other bits of the word are set to a fixed pattern.

Top module: `i2c_scl_gen`

## Requirements
- R1: Out of reset `scl_o` is 1 and `pull_o`, `release_o` and `tick_o` are 0.
- R2: While `run_i` is 0, `scl_o` stays 1 and `pull_o`, `release_o` and `tick_o` stay 0, whatever `timing_i` holds.
- R3: With E = `timing_i[3:0]` and L = `timing_i[15:12]`, every low phase of `scl_o` lasts (L+1)·2^E clock cycles.
- R4: With H = `timing_i[19:16]`, every high phase of `scl_o` lasts (H+1)·2^E clock cycles.
- R5: `pull_o` is 1 for exactly the first cycle of each low phase, and `release_o` is 1 for exactly the first cycle of each high phase.
- R6: `timing_i` is captured only when a low phase starts. A change made during a period leaves the rest of that low phase and the following high phase unchanged. It applies from the next low phase on.
- R7: When `run_i` drops, `scl_o` returns to 1 in the next cycle. When `run_i` rises, `scl_o` goes low and `pull_o` pulses in the next cycle.
- R8: While running, `tick_o` pulses once every 2^E cycles. The first pulse comes in cycle 2^E−1, counted from the first cycle of a low phase.
- R9: The helper ratio is PCLK_HZ / `speed_i` in integer division. The helper exponent is the number of halvings needed to bring the ratio below 16. The reduced ratio is incremented once if any bit shifted out was 1.
- R10: With r the reduced ratio, the helper sets low = r/2 − 1 and high = r − low − 2. Its word is 0x77700300 OR (high<<16) OR (low<<12) OR exponent.
- R11: A `speed_i` of 0 is rejected: `calc_ok_o` is 0 and `calc_word_o` is 0. Any other speed gives `calc_ok_o` = 1.
- R12: A reduced ratio below 2 gives low = high = 0. An exponent above 15 saturates the exponent, low and high fields to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables serial clock generation |
| timing_i | input | 32 | Timing word: E [3:0], L [15:12], H [19:16] |
| speed_i | input | 32 | Requested bus speed in Hz, input to the helper |
| calc_word_o | output | 32 | Timing word computed from `speed_i` |
| calc_ok_o | output | 1 | Helper result is valid (nonzero speed) |
| scl_o | output | 1 | Serial clock level, 0 low and 1 released |
| pull_o | output | 1 | Strobe on the first cycle of a low phase |
| release_o | output | 1 | Strobe on the first cycle of a high phase |
| tick_o | output | 1 | Base tick from the prescaler |

## Verification
Several internal faults show up at the ports within one serial clock period:
- A prescaler fault or a phase-count fault stretches or shortens a phase by whole ticks. The first measured low or high phase then has the wrong length.
- A shadow register that captures at the wrong moment makes a mid-period timing change alter the phase in progress. The phase measurement just after the change catches this.
- A strobe that is misplaced by even one cycle no longer matches the first cycle of its phase.

The helper is purely combinational, so a wrong exponent, rounding or clamp appears in `calc_word_o` in the same cycle.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int FIELD_W  = 4;
  localparam int WORD_W   = 32;
  localparam int EXP_LSB  = 0;
  localparam int LOW_LSB  = 12;
  localparam int HIGH_LSB = 16;
  localparam int MAX_FLD  = (1 << FIELD_W) - 1;
  localparam int PRE_W    = MAX_FLD;
  localparam logic [WORD_W-1:0] FIXED_BITS = 32'h7770_0300;

  typedef struct packed {
    logic [FIELD_W-1:0] high;
    logic [FIELD_W-1:0] low;
    logic [FIELD_W-1:0] expo;
  } scl_cfg_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;
endpackage

// File: rtl/scl_ratio_calc.sv
module scl_ratio_calc
  import i2c_scl_pkg::*;
#(
  parameter int unsigned PCLK_HZ = 50_000_000,
  parameter int          SPD_W   = 32
) (
  input  logic [SPD_W-1:0]  speed_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ok_o
);
  localparam int CNT_W = $clog2(SPD_W + 1);
  localparam logic [SPD_W-1:0] PCLK_V = SPD_W'(PCLK_HZ);
  localparam logic [SPD_W-1:0] LIMIT  = SPD_W'(MAX_FLD + 1);

  logic [SPD_W-1:0]   ratio, red;
  logic [CNT_W-1:0]   n_div;
  logic               sticky;
  logic [FIELD_W-1:0] f_exp, f_low, f_high;

  always_comb begin
    ratio  = (speed_i == '0) ? '0 : PCLK_V / speed_i;
    red    = ratio;
    sticky = 1'b0;
    n_div  = '0;
    for (int i = 0; i < SPD_W; i++) begin
      if (red >= LIMIT) begin
        sticky = sticky | red[0];
        red    = red >> 1;
        n_div  = n_div + 1'b1;
      end
    end
    red = red + SPD_W'(sticky);
    if (32'(n_div) > MAX_FLD) begin
      f_exp  = FIELD_W'(MAX_FLD);
      f_low  = FIELD_W'(MAX_FLD);
      f_high = FIELD_W'(MAX_FLD);
    end else if (red < SPD_W'(2)) begin
      f_exp  = FIELD_W'(n_div);
      f_low  = '0;
      f_high = '0;
    end else begin
      f_exp  = FIELD_W'(n_div);
      f_low  = FIELD_W'((red >> 1) - 1);
      f_high = FIELD_W'(red - (red >> 1) - 1);
    end
  end

  assign ok_o   = (speed_i != '0);
  assign word_o = ok_o ? (FIXED_BITS
                          | (WORD_W'(f_high) << HIGH_LSB)
                          | (WORD_W'(f_low)  << LOW_LSB)
                          | (WORD_W'(f_exp)  << EXP_LSB)) : '0;

  always_comb begin
    // R10
    high_ge_low_chk: assert (!ok_o || f_high >= f_low);
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import i2c_scl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [FIELD_W-1:0] expo_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] wrap;
  logic             hit;

  assign wrap   = PRE_W'((1 << expo_i) - 1);
  assign hit    = (cnt_q == wrap);
  assign tick_o = hit & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || hit)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R8
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clear_i) |=> (expo_i == '0) || !tick_o);
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import i2c_scl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  scl_cfg_t           cfg_i,
  output logic [FIELD_W-1:0] expo_o,
  output logic               active_o,
  output logic               scl_o,
  output logic               pull_o,
  output logic               release_o
);
  scl_cfg_t           shadow_q;
  scl_phase_e         phase_q;
  logic               active_q, pull_q, rel_q;
  logic [FIELD_W-1:0] cnt_q, limit;

  assign limit = (phase_q == PH_LOW) ? shadow_q.low : shadow_q.high;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      shadow_q <= '0;
      pull_q   <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      pull_q <= 1'b0;
      rel_q  <= 1'b0;
      if (!run_i) begin
        active_q <= 1'b0;
        phase_q  <= PH_HIGH;
        cnt_q    <= '0;
      end else if (!active_q) begin
        active_q <= 1'b1;
        phase_q  <= PH_LOW;
        cnt_q    <= '0;
        shadow_q <= cfg_i;
        pull_q   <= 1'b1;
      end else if (tick_i) begin
        if (cnt_q == limit) begin
          cnt_q <= '0;
          if (phase_q == PH_LOW) begin
            phase_q <= PH_HIGH;
            rel_q   <= 1'b1;
          end else begin
            phase_q  <= PH_LOW;
            shadow_q <= cfg_i;
            pull_q   <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expo_o    = shadow_q.expo;
  assign active_o  = active_q;
  assign scl_o     = ~active_q | (phase_q == PH_HIGH);
  assign pull_o    = pull_q;
  assign release_o = rel_q;

  // R5
  pull_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> !scl_o);
  // R5
  release_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> scl_o);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pull_o, release_o}));
  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_o && !pull_o && !release_o));
  // R6
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shadow_q) |-> pull_o);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int unsigned PCLK_HZ = 50_000_000,
  parameter int          SPD_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [WORD_W-1:0] timing_i,
  input  logic [SPD_W-1:0]  speed_i,
  output logic [WORD_W-1:0] calc_word_o,
  output logic              calc_ok_o,
  output logic              scl_o,
  output logic              pull_o,
  output logic              release_o,
  output logic              tick_o
);
  scl_cfg_t           cfg;
  logic [FIELD_W-1:0] expo;
  logic               active, tick;
  logic               cfg_unused;

  assign cfg.expo  = timing_i[EXP_LSB  +: FIELD_W];
  assign cfg.low   = timing_i[LOW_LSB  +: FIELD_W];
  assign cfg.high  = timing_i[HIGH_LSB +: FIELD_W];
  assign cfg_unused = ^{timing_i[WORD_W-1:HIGH_LSB+FIELD_W],
                        timing_i[LOW_LSB-1:EXP_LSB+FIELD_W]};

  scl_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~active),
    .expo_i  (expo),
    .tick_o  (tick)
  );

  scl_phase_ctrl u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .tick_i    (tick),
    .cfg_i     (cfg),
    .expo_o    (expo),
    .active_o  (active),
    .scl_o     (scl_o),
    .pull_o    (pull_o),
    .release_o (release_o)
  );

  scl_ratio_calc #(.PCLK_HZ(PCLK_HZ), .SPD_W(SPD_W)) u_calc (
    .speed_i (speed_i),
    .word_o  (calc_word_o),
    .ok_o    (calc_ok_o)
  );

  assign tick_o = tick;
endmodule

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] timing = '0;
  logic [31:0] speed = '0;
  logic [31:0] calc_word;
  logic        calc_ok, scl, pull, rel, tick;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_scl_gen u_i2c_scl_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .timing_i(timing),
    .speed_i(speed), .calc_word_o(calc_word), .calc_ok_o(calc_ok),
    .scl_o(scl), .pull_o(pull), .release_o(rel), .tick_o(tick)
  );

  function automatic logic [31:0] mk(int e, int l, int h);
    return 32'h7770_0300 | (32'(h) << 16) | (32'(l) << 12) | 32'(e);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pull();
    int n = 0;
    while (!pull && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int lo_n, output int hi_n, output int pulls,
                         output bit rel_first);
    lo_n = 0; hi_n = 0; pulls = 0; rel_first = 0;
    while (!scl && lo_n < 20000) begin
      if (pull) pulls++;
      lo_n++; @(negedge clk);
    end
    rel_first = rel;
    while (scl && hi_n < 20000) begin
      hi_n++; @(negedge clk);
    end
  endtask

  task automatic stop_run();
    @(negedge clk); run = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset_idle();
    check(scl == 1 && !pull && !rel && !tick, "R1 reset state",
          {scl, pull, rel, tick}, 4'b1000);
    timing = mk(0, 1, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(scl && !pull && !rel && !tick)) begin
        check(0, "R2 idle outputs", {scl, pull, rel, tick}, 4'b1000);
        break;
      end
    end
    check(scl == 1, "R2 idle scl", scl, 1);
  endtask

  task automatic t_period(int e, int l, int h);
    int lo_n, hi_n, pulls; bit rf;
    @(negedge clk); timing = mk(e, l, h); run = 1'b1;
    @(negedge clk);
    wait_pull();
    measure(lo_n, hi_n, pulls, rf);
    check(lo_n == (l + 1) << e, "R3 low length", lo_n, (l + 1) << e);
    check(hi_n == (h + 1) << e, "R4 high length", hi_n, (h + 1) << e);
    check(pulls == 1 && rf && pull, "R5 strobes", {pulls[3:0], rf, pull}, 6'b000111);
    measure(lo_n, hi_n, pulls, rf);
    check(lo_n == (l + 1) << e && hi_n == (h + 1) << e, "R3 R4 second period",
          {lo_n[15:0], hi_n[15:0]}, {16'((l + 1) << e), 16'((h + 1) << e)});
    stop_run();
  endtask

  task automatic t_update();
    int lo_n, hi_n, pulls; bit rf;
    @(negedge clk); timing = mk(0, 3, 3); run = 1'b1;
    @(negedge clk);
    wait_pull();
    timing = mk(1, 1, 5);
    measure(lo_n, hi_n, pulls, rf);
    check(lo_n == 4 && hi_n == 4, "R6 old timing kept", {lo_n[15:0], hi_n[15:0]},
          {16'd4, 16'd4});
    measure(lo_n, hi_n, pulls, rf);
    check(lo_n == 4 && hi_n == 12, "R6 new timing applied",
          {lo_n[15:0], hi_n[15:0]}, {16'd4, 16'd12});
    stop_run();
  endtask

  task automatic t_stop_start();
    int lo_n, hi_n, pulls; bit rf;
    @(negedge clk); timing = mk(0, 5, 5); run = 1'b1;
    @(negedge clk);
    wait_pull();
    @(negedge clk); @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(scl == 1 && !pull && !rel, "R7 stop releases", {scl, pull, rel}, 3'b100);
    @(negedge clk); @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    check(scl == 0 && pull == 1, "R7 restart pulls", {scl, pull}, 2'b01);
    measure(lo_n, hi_n, pulls, rf);
    check(lo_n == 6 && hi_n == 6, "R7 restart full period",
          {lo_n[15:0], hi_n[15:0]}, {16'd6, 16'd6});
    stop_run();
  endtask

  task automatic t_tick();
    int n_tick = 0; int first = -1;
    @(negedge clk); timing = mk(2, 1, 1); run = 1'b1;
    @(negedge clk);
    wait_pull();
    for (int i = 0; i < 16; i++) begin
      if (tick) begin
        n_tick++;
        if (first < 0) first = i;
      end
      @(negedge clk);
    end
    check(n_tick == 4, "R8 tick count", n_tick, 4);
    check(first == 3, "R8 first tick", first, 3);
    stop_run();
  endtask

  task automatic t_calc(int unsigned spd, logic [31:0] exp_w, bit exp_ok, string req);
    @(negedge clk); speed = spd;
    @(negedge clk);
    check(calc_word == exp_w && calc_ok == exp_ok, req,
          {calc_ok, calc_word}, {exp_ok, exp_w});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_period(0, 2, 3);
    t_period(1, 2, 3);
    t_period(0, 0, 0);
    t_period(2, 4, 1);
    t_update();
    t_stop_start();
    t_tick();
    // R9/R10: 500 -> exp 5, r 16, low 7, high 7
    t_calc(100_000, 32'h7777_7305, 1, "R9 R10 ratio 500");
    t_calc(400_000, 32'h7777_7303, 1, "R9 ratio 125 round-up");
    t_calc(5_000_000, 32'h7774_4300, 1, "R10 ratio 10");
    t_calc(3_846_153, 32'h7776_5300, 1, "R10 ratio 13 odd");
    t_calc(1_562_500, 32'h7773_3302, 1, "R9 ratio 32 exact");
    t_calc(1_612_903, 32'h7777_7301, 1, "R9 ratio 31 sticky");
    t_calc(0, 32'h0, 0, "R11 zero speed");
    t_calc(50_000_000, 32'h7770_0300, 1, "R12 ratio 1 clamp");
    t_calc(16_000_000, 32'h7771_0300, 1, "R12 ratio 3");
    t_calc(1, 32'h777F_F30F, 1, "R12 exponent saturate");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule